// File: doc/BRIEF.md
# Graphics Command Packet Parser

This block sits at the front of a rasteriser and takes in a stream of 32-bit command words. It groups the words into whole packets. The opcode in the top byte of a packet's first word sets how many words the packet has. The block keeps an unfinished packet in a small register file until its last word arrives. It then sends the packet downstream one word at a time over a valid/ready port, with a last flag on the final word. While it is collecting a packet it accepts no new words.

As words arrive, the block copies selected bits of certain words into a 13-bit status register:
- attribute-setting opcodes write their own bits into it;
- textured primitives write the bits of one particular vertex word into it.

Two opcodes open an image transfer. Their position word and size word go to a separate transfer engine through a one-cycle start strobe, and the opcode packet itself is not sent downstream. For a host-to-memory write, the words that follow go straight to the engine until the engine reports completion. For a memory-to-host read, parsing resumes at once.

Top module: `gfx_cmd_parser`

## Requirements
- R1: After reset, `pkt_valid`, `pkt_last`, `xfer_start` and `xfer_wvalid` are low, `in_ready` is high and `status` is zero.
- R2: The total packet length in words depends on the opcode (first word bits [31:24]):
  - 12 words for 0x3C–0x3F;
  - 9 for 0x2C–0x2F and 0x34–0x37;
  - 8 for 0x38–0x3B;
  - 7 for 0x24–0x27;
  - 6 for 0x30–0x33;
  - 5 for 0x28–0x2B and 0x58–0x5F;
  - 4 for 0x20–0x23, 0x48–0x53, 0x64–0x67 and 0x80;
  - 3 for 0x02, 0x40–0x43, 0x60–0x63, 0x6C–0x6F, 0x74–0x77, 0x7C–0x7F, 0xA0 and 0xC0;
  - 2 for 0x68–0x6B, 0x70–0x73 and 0x78–0x7B;
  - 1 for every other opcode.
- R3: A drawing packet is released only when all of its words are present. Its words then appear on `pkt_data` in arrival order, and `pkt_last` is high on exactly the final word.
- R4: While a packet is being released, `in_ready` is low. While `pkt_ready` is low, `pkt_data` and `pkt_last` hold their values.
- R5: If (opcode & 0xF4) == 0x24, accepting word index 4 of the packet (the opcode word is index 0) copies its bits [8:0] into `status[8:0]`, visible the cycle after acceptance.
- R6: If (opcode & 0xF4) == 0x34, accepting word index 5 copies its bits [8:0] into `status[8:0]`, visible the cycle after acceptance.
- R7: Opcode 0xE1 copies bits [10:0] of its own word into `status[10:0]`. Opcode 0xE6 copies bits [1:0] of its own word into `status[12:11]`. Both are visible the cycle after acceptance.
- R8: For opcodes 0xA0 and 0xC0, the cycle after the third word is accepted, `xfer_start` pulses for one cycle. At that time `xfer_pos` holds word 1, `xfer_size` holds word 2, and `xfer_read` is 1 only for 0xC0. The packet is never presented on `pkt_valid`.
- R9: After 0xA0, every word accepted goes out on `xfer_wdata` with `xfer_wvalid` and is not parsed. This continues until the cycle in which `xfer_done` is high, inclusive; command parsing resumes on the next cycle. After 0xC0, parsing resumes immediately.
- R10: Gaps in `in_valid` between the words of a packet do not change the packet or the moment it is released relative to its last word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Command word present |
| in_ready | output | 1 | Command word accepted when high with in_valid |
| in_data | input | 32 | Command or transfer data word |
| pkt_valid | output | 1 | Packet word available downstream |
| pkt_ready | input | 1 | Downstream takes the word |
| pkt_data | output | 32 | Packet word |
| pkt_last | output | 1 | Final word of the packet |
| status | output | 13 | Snooped status bits |
| xfer_start | output | 1 | One-cycle transfer start strobe |
| xfer_read | output | 1 | 1 = memory-to-host, 0 = host-to-memory |
| xfer_pos | output | 32 | Transfer position word |
| xfer_size | output | 32 | Transfer size word |
| xfer_wvalid | output | 1 | Write-transfer data word valid |
| xfer_wdata | output | 32 | Write-transfer data word |
| xfer_done | input | 1 | Transfer engine finished the write transfer |

## Verification
Acceptance is combinational, so `in_ready`, `xfer_wvalid` and `xfer_wdata` are due in the same cycle as the input. Status updates, the start strobe and the first released packet word all appear one edge after the word that triggers them is accepted. The bench drives inputs after the falling edge, waits one time unit, and compares every output with a behavioural model. The model advances only after the comparison, so each expectation refers to exactly the cycle in which the design must show it.

// File: rtl/gcp_pkg.sv
package gcp_pkg;
    localparam int DATA_W  = 32;
    localparam int BUF_DEPTH = 16;
    localparam int IDX_W   = $clog2(BUF_DEPTH);
    localparam int LEN_W   = IDX_W + 1;
    localparam int STAT_W  = 13;
    localparam int SNOOP_W = 11;

    localparam logic [7:0] OP_IMG_WR = 8'hA0;
    localparam logic [7:0] OP_IMG_RD = 8'hC0;
    localparam logic [7:0] OP_ATTR   = 8'hE1;
    localparam logic [7:0] OP_WMASK  = 8'hE6;

    typedef enum logic [1:0] {
        ST_COLLECT = 2'd0,
        ST_DRAIN   = 2'd1,
        ST_XFER    = 2'd2
    } parse_state_e;

    // Total words in a packet, opcode word included.
    function automatic logic [LEN_W-1:0] total_words(input logic [7:0] op);
        logic [LEN_W-1:0] n;
        unique case (op[7:2])
            6'h08:                      n = LEN_W'(4);
            6'h09:                      n = LEN_W'(7);
            6'h0A:                      n = LEN_W'(5);
            6'h0B, 6'h0D:               n = LEN_W'(9);
            6'h0C:                      n = LEN_W'(6);
            6'h0E:                      n = LEN_W'(8);
            6'h0F:                      n = LEN_W'(12);
            6'h10, 6'h18, 6'h1B,
            6'h1D, 6'h1F:               n = LEN_W'(3);
            6'h12, 6'h13, 6'h14, 6'h19: n = LEN_W'(4);
            6'h16, 6'h17:               n = LEN_W'(5);
            6'h1A, 6'h1C, 6'h1E:        n = LEN_W'(2);
            default: begin
                if (op == 8'h02 || op == OP_IMG_WR || op == OP_IMG_RD)
                    n = LEN_W'(3);
                else if (op == 8'h80)
                    n = LEN_W'(4);
                else
                    n = LEN_W'(1);
            end
        endcase
        return n;
    endfunction
endpackage

// File: rtl/gcp_len_lookup.sv
module gcp_len_lookup
    import gcp_pkg::*;
(
    input  logic [7:0]       opcode,
    output logic [LEN_W-1:0] words
);
    always_comb begin
        words = total_words(opcode);
    end
endmodule

// File: rtl/gcp_status_snoop.sv
module gcp_status_snoop
    import gcp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc,
    input  logic [IDX_W-1:0]   idx,
    input  logic [7:0]         opcode,
    input  logic [SNOOP_W-1:0] word,
    output logic [STAT_W-1:0]  status
);
    logic [STAT_W-1:0] stat_d, stat_q;

    always_comb begin
        stat_d = stat_q;
        if (acc) begin
            if (idx == '0 && opcode == OP_ATTR)
                stat_d[10:0] = word[10:0];
            if (idx == '0 && opcode == OP_WMASK)
                stat_d[12:11] = word[1:0];
            if ((opcode & 8'hF4) == 8'h24 && idx == IDX_W'(4))
                stat_d[8:0] = word[8:0];
            if ((opcode & 8'hF4) == 8'h34 && idx == IDX_W'(5))
                stat_d[8:0] = word[8:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    assign status = stat_q;

    // R5
    no_idle_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> $stable(status));
endmodule

// File: rtl/gcp_pkt_store.sv
module gcp_pkt_store
    import gcp_pkg::*;
(
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [BUF_DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/gfx_cmd_parser.sv
module gfx_cmd_parser
    import gcp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              pkt_valid,
    input  logic              pkt_ready,
    output logic [DATA_W-1:0] pkt_data,
    output logic              pkt_last,
    output logic [STAT_W-1:0] status,
    output logic              xfer_start,
    output logic              xfer_read,
    output logic [DATA_W-1:0] xfer_pos,
    output logic [DATA_W-1:0] xfer_size,
    output logic              xfer_wvalid,
    output logic [DATA_W-1:0] xfer_wdata,
    input  logic              xfer_done
);
    typedef struct packed {
        parse_state_e      state;
        logic [IDX_W-1:0]  cnt;
        logic [LEN_W-1:0]  len;
        logic [7:0]        op;
        logic [IDX_W-1:0]  rd;
        logic              xstart;
        logic              xread;
        logic [DATA_W-1:0] pos;
        logic [DATA_W-1:0] size;
    } parse_regs_t;

    parse_regs_t r_d, r_q;

    logic             acc_cmd;
    logic [7:0]       op_eff;
    logic [LEN_W-1:0] lut_len;
    logic [LEN_W-1:0] len_eff;
    logic             complete;
    logic             is_img;
    logic             at_last;

    assign acc_cmd  = (r_q.state == ST_COLLECT) && in_valid;
    assign op_eff   = (r_q.cnt == '0) ? in_data[31:24] : r_q.op;

    gcp_len_lookup u_len (
        .opcode (in_data[31:24]),
        .words  (lut_len)
    );

    assign len_eff  = (r_q.cnt == '0) ? lut_len : r_q.len;
    assign complete = acc_cmd && (({1'b0, r_q.cnt} + LEN_W'(1)) == len_eff);
    assign is_img   = (op_eff == OP_IMG_WR) || (op_eff == OP_IMG_RD);
    assign at_last  = ({1'b0, r_q.rd} == (r_q.len - LEN_W'(1)));

    always_comb begin
        r_d        = r_q;
        r_d.xstart = 1'b0;
        unique case (r_q.state)
            ST_COLLECT: begin
                if (in_valid) begin
                    r_d.cnt = r_q.cnt + IDX_W'(1);
                    r_d.op  = op_eff;
                    r_d.len = len_eff;
                    if (r_q.cnt == IDX_W'(1) && is_img)
                        r_d.pos = in_data;
                    if (complete) begin
                        r_d.cnt = '0;
                        r_d.rd  = '0;
                        if (is_img) begin
                            r_d.size   = in_data;
                            r_d.xstart = 1'b1;
                            r_d.xread  = (op_eff == OP_IMG_RD);
                            r_d.state  = (op_eff == OP_IMG_WR) ? ST_XFER : ST_COLLECT;
                        end else begin
                            r_d.state = ST_DRAIN;
                        end
                    end
                end
            end
            ST_DRAIN: begin
                if (pkt_ready) begin
                    if (at_last) begin
                        r_d.rd    = '0;
                        r_d.state = ST_COLLECT;
                    end else begin
                        r_d.rd = r_q.rd + IDX_W'(1);
                    end
                end
            end
            ST_XFER: begin
                if (xfer_done) r_d.state = ST_COLLECT;
            end
            default: r_d.state = ST_COLLECT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_COLLECT;
        end else begin
            r_q <= r_d;
        end
    end

    gcp_pkt_store u_store (
        .clk   (clk),
        .we    (acc_cmd),
        .waddr (r_q.cnt),
        .wdata (in_data),
        .raddr (r_q.rd),
        .rdata (pkt_data)
    );

    gcp_status_snoop u_snoop (
        .clk    (clk),
        .rst_n  (rst_n),
        .acc    (acc_cmd),
        .idx    (r_q.cnt),
        .opcode (op_eff),
        .word   (in_data[SNOOP_W-1:0]),
        .status (status)
    );

    assign in_ready    = (r_q.state != ST_DRAIN);
    assign pkt_valid   = (r_q.state == ST_DRAIN);
    assign pkt_last    = pkt_valid && at_last;
    assign xfer_start  = r_q.xstart;
    assign xfer_read   = r_q.xread;
    assign xfer_pos    = r_q.pos;
    assign xfer_size   = r_q.size;
    assign xfer_wvalid = (r_q.state == ST_XFER) && in_valid;
    assign xfer_wdata  = in_data;

    // R4
    hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid && !pkt_ready |=> pkt_valid && $stable(pkt_data) && $stable(pkt_last));
    // R4
    no_accept_in_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> !in_ready);
    // R8
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> !xfer_start);
    // R9
    xfer_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_wvalid |-> !pkt_valid);
    // R3
    last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_last |-> pkt_valid);
endmodule

// File: tb/tb_gfx_cmd_parser.sv
`timescale 1ns/1ps
module tb_gfx_cmd_parser;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        pkt_valid;
    logic        pkt_ready = 1'b0;
    logic [31:0] pkt_data;
    logic        pkt_last;
    logic [12:0] status;
    logic        xfer_start, xfer_read, xfer_wvalid;
    logic [31:0] xfer_pos, xfer_size, xfer_wdata;
    logic        xfer_done = 1'b0;

    always #10 clk = ~clk;

    gfx_cmd_parser dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_data(pkt_data),
        .pkt_last(pkt_last), .status(status),
        .xfer_start(xfer_start), .xfer_read(xfer_read),
        .xfer_pos(xfer_pos), .xfer_size(xfer_size),
        .xfer_wvalid(xfer_wvalid), .xfer_wdata(xfer_wdata),
        .xfer_done(xfer_done)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // behavioural reference model
    int          m_mode = 0;      // 0 collect, 1 release, 2 write transfer
    logic [31:0] m_pkt[$];
    int          m_len = 0;
    int          m_rd = 0;
    logic [12:0] m_stat = '0;
    bit          m_xs = 0;
    bit          m_xread = 0;
    logic [31:0] m_xpos = '0, m_xsize = '0;
    bit          m_acc = 0;

    function automatic int words_for(input logic [7:0] op);
        if (op inside {[8'h3C:8'h3F]}) return 12;
        if (op inside {[8'h2C:8'h2F], [8'h34:8'h37]}) return 9;
        if (op inside {[8'h38:8'h3B]}) return 8;
        if (op inside {[8'h24:8'h27]}) return 7;
        if (op inside {[8'h30:8'h33]}) return 6;
        if (op inside {[8'h28:8'h2B], [8'h58:8'h5F]}) return 5;
        if (op inside {[8'h20:8'h23], [8'h48:8'h53], [8'h64:8'h67], 8'h80}) return 4;
        if (op inside {8'h02, [8'h40:8'h43], [8'h60:8'h63], [8'h6C:8'h6F],
                       [8'h74:8'h77], [8'h7C:8'h7F], 8'hA0, 8'hC0}) return 3;
        if (op inside {[8'h68:8'h6B], [8'h70:8'h73], [8'h78:8'h7B]}) return 2;
        return 1;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic cycle(input logic v, input logic [31:0] d, input logic pr,
                         input logic xd);
        int idx;
        logic [7:0] op;
        in_valid = v; in_data = d; pkt_ready = pr; xfer_done = xd;
        #1;
        chk(in_ready === (m_mode != 1), "R4 in_ready", 32'(in_ready), 32'(m_mode != 1));
        chk(pkt_valid === (m_mode == 1), "R3 pkt_valid", 32'(pkt_valid), 32'(m_mode == 1));
        if (m_mode == 1) begin
            chk(pkt_data === m_pkt[m_rd], "R3 pkt_data", pkt_data, m_pkt[m_rd]);
            chk(pkt_last === (m_rd == m_len - 1), "R2,R3 pkt_last", 32'(pkt_last),
                32'(m_rd == m_len - 1));
        end
        chk(status === m_stat, "R5,R6,R7 status", 32'(status), 32'(m_stat));
        chk(xfer_start === m_xs, "R8 xfer_start", 32'(xfer_start), 32'(m_xs));
        if (m_xs) begin
            chk(xfer_pos === m_xpos, "R8 xfer_pos", xfer_pos, m_xpos);
            chk(xfer_size === m_xsize, "R8 xfer_size", xfer_size, m_xsize);
            chk(xfer_read === m_xread, "R8 xfer_read", 32'(xfer_read), 32'(m_xread));
        end
        chk(xfer_wvalid === (m_mode == 2 && v), "R9 xfer_wvalid", 32'(xfer_wvalid),
            32'(m_mode == 2 && v));
        if (m_mode == 2 && v) chk(xfer_wdata === d, "R9 xfer_wdata", xfer_wdata, d);

        // advance the model
        m_acc = 0;
        m_xs = 0;
        if (m_mode == 1) begin
            if (pr) begin
                if (m_rd == m_len - 1) begin
                    m_mode = 0; m_pkt.delete(); m_rd = 0;
                end else m_rd++;
            end
        end else if (m_mode == 2) begin
            m_acc = v;
            if (xd) m_mode = 0;
        end else if (v) begin
            m_acc = 1;
            idx = m_pkt.size();
            m_pkt.push_back(d);
            if (idx == 0) m_len = words_for(d[31:24]);
            op = m_pkt[0][31:24];
            if (idx == 0 && op == 8'hE1) m_stat[10:0] = d[10:0];
            if (idx == 0 && op == 8'hE6) m_stat[12:11] = d[1:0];
            if (idx == 4 && op inside {[8'h24:8'h27], [8'h2C:8'h2F]}) m_stat[8:0] = d[8:0];
            if (idx == 5 && op inside {[8'h34:8'h37], [8'h3C:8'h3F]}) m_stat[8:0] = d[8:0];
            if (m_pkt.size() == m_len) begin
                if (op == 8'hA0 || op == 8'hC0) begin
                    m_xs = 1; m_xpos = m_pkt[1]; m_xsize = m_pkt[2];
                    m_xread = (op == 8'hC0);
                    m_mode = (op == 8'hA0) ? 2 : 0;
                    m_pkt.delete();
                end else begin
                    m_mode = 1; m_rd = 0;
                end
            end
        end
        cyc++;
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic stall_pat();
        return (cyc % 3) != 1;
    endfunction

    task automatic push(input logic [31:0] d, input bit gap);
        int guard = 0;
        if (gap) cycle(1'b0, 32'hDEAD_0000, stall_pat(), 1'b0);
        do begin
            cycle(1'b1, d, stall_pat(), 1'b0);
            guard++;
        end while (!m_acc && guard < 100);
    endtask

    task automatic drain();
        int guard = 0;
        while (m_mode == 1 && guard < 200) begin
            cycle(1'b0, '0, stall_pat(), 1'b0);
            guard++;
        end
    endtask

    task automatic send_pkt(input logic [7:0] op, input logic [23:0] lo,
                            input logic [31:0] seed, input bit gap);
        int n = words_for(op);
        push({op, lo}, gap);
        for (int i = 1; i < n; i++) push(seed + 32'(i * 32'h0101_0037), gap);
        drain();
    endtask

    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(pkt_valid === 1'b0, "R1 pkt_valid", 32'(pkt_valid), 0);
        chk(pkt_last === 1'b0, "R1 pkt_last", 32'(pkt_last), 0);
        chk(in_ready === 1'b1, "R1 in_ready", 32'(in_ready), 1);
        chk(status === '0, "R1 status", 32'(status), 0);
        chk(xfer_start === 1'b0, "R1 xfer_start", 32'(xfer_start), 0);
        chk(xfer_wvalid === 1'b0, "R1 xfer_wvalid", 32'(xfer_wvalid), 0);

        // R7 attribute opcodes
        send_pkt(8'hE1, 24'h0005A5, 32'h0, 0);
        send_pkt(8'hE6, 24'h000003, 32'h0, 0);
        send_pkt(8'hE6, 24'h000002, 32'h0, 1);
        // R2,R3 plain packets
        send_pkt(8'h20, 24'h123456, 32'h1111_0000, 0);
        send_pkt(8'h02, 24'h0000FF, 32'h2222_0000, 0);
        // R5 flat textured, with stalls downstream
        send_pkt(8'h24, 24'h000000, 32'h0000_01C3, 0);
        send_pkt(8'h2D, 24'h000000, 32'h0000_0077, 0);
        // R6 shaded textured
        send_pkt(8'h34, 24'h000000, 32'h0000_0155, 0);
        send_pkt(8'h3E, 24'h000000, 32'h0000_0099, 0);
        // R10 gaps between words
        send_pkt(8'h3C, 24'hABCDEF, 32'h3333_0000, 1);
        send_pkt(8'h80, 24'h000001, 32'h4444_0000, 1);

        // R8,R9 image write then data then done
        push(32'hA000_0000, 0);
        push(32'h0010_0020, 0);
        push(32'h0004_0008, 0);
        for (int i = 0; i < 5; i++) cycle(1'b1, 32'hE100_0000 + 32'(i), 1'b1, 1'b0);
        cycle(1'b0, '0, 1'b1, 1'b0);
        cycle(1'b1, 32'hE100_07FF, 1'b1, 1'b1);
        send_pkt(8'h68, 24'h000010, 32'h5555_0000, 0);

        // R8 image read resumes parsing at once
        push(32'hC000_0000, 0);
        push(32'h0001_0002, 0);
        push(32'h0003_0004, 0);
        send_pkt(8'h70, 24'h000020, 32'h6666_0000, 0);

        // R2 every opcode except write transfer
        for (int op = 0; op < 256; op++) begin
            if (op != 8'hA0) send_pkt(8'(op), 24'(op * 3), 32'(op << 12), (op % 5) == 0);
        end

        drain();
        repeat (2) cycle(1'b0, '0, 1'b1, 1'b0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule